// File: doc/BRIEF.md
# Packet Payload Endian Converter

This block sits on the payload path between a byte-addressed local DMA engine and a serial packet engine. The link always carries payloads big-endian, aligned to 64-bit double-words. The block takes 64-bit payload beats with a valid/ready handshake and presents them one register stage later. When the device runs little-endian and the packet type calls for it, the block reverses the byte order inside each 32-bit word. Beats that belong to local configuration-bus accesses are never altered.

At the start of each packet the block captures the endian mode, packet type, payload byte count, role (initiator or target) and configuration-access flag. These values govern every beat of that packet. For maintenance packets the block also checks the payload size, using separate rules for the initiator and target roles. A packet with an illegal size is consumed and discarded, and an error flag stays raised until the next packet begins.

Top module: `payload_endian_conv`

## Requirements
- R1: With `little_endian` low, every forwarded beat leaves with `out_data` equal to its `in_data`, whatever the packet type.
- R2: With `little_endian` high and a packet type of 0 (NWRITE), 1 (NWRITE_R), 2 (SWRITE), 3 (NREAD), 4 (message) or 5 (maintenance), the four bytes of each 32-bit word are reversed: byte k of word w (bits 32w+8k+7:32w+8k) moves to byte 3-k of the same word.
- R3: Packet types 6 and 7 are forwarded unchanged in either endian mode.
- R4: A packet whose `in_cfg` is high at start-of-packet is forwarded unchanged and is exempt from the maintenance size check.
- R5: For a converted packet with a byte count of 4, only a 32-bit word whose byte-enable nibble (`in_be[4w+3:4w]`) is non-zero is reversed; the other word passes unchanged.
- R6: An initiator maintenance packet (type 5, `in_target` low) is legal with a byte count of 4, or a non-zero multiple of 8 no greater than 64. Any other count raises `size_err` one cycle after the start-of-packet beat is accepted.
- R7: A target maintenance packet (`in_target` high) is legal only with a byte count of 4. Any other count raises `size_err` as in R6.
- R8: Every beat of an illegally sized packet is accepted and discarded. `size_err` stays high until the next start-of-packet beat is accepted, and then takes the verdict of that packet.
- R9: Endian mode, packet type, byte count, role and configuration flag are taken only from the start-of-packet beat. Their values on later beats have no effect.
- R10: An accepted beat appears at the output on the next cycle, with `out_be`, `out_sop` and `out_eop` copied from the input. While `out_ready` is low the output holds steady. No beat is lost or repeated.
- R11: After reset `out_valid` and `size_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| little_endian | input | 1 | Device memory runs little-endian |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_ptype | input | 3 | Packet type code |
| in_bytes | input | 7 | Payload byte count |
| in_target | input | 1 | Block acts as target for this packet |
| in_cfg | input | 1 | Local configuration-bus access |
| in_data | input | 64 | Payload beat |
| in_be | input | 8 | Byte enables of the beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_data | output | 64 | Converted beat |
| out_be | output | 8 | Byte enables of the beat |
| size_err | output | 1 | Maintenance size error, held until the next packet |

## Verification
The hardest case to reach from the ports is a start-of-packet beat that arrives while the output register is stalled, followed by mid-packet beats whose header inputs disagree with the captured ones. Here the captured header and the discard decision must survive stall cycles. To reach it, the stimulus scrambles the header inputs on every non-first beat and drives `out_ready` from a pseudo-random pattern with long low runs. Legal and illegal maintenance packets are sent back to back, so the error flag also has to clear and re-arm in the middle of that backpressure.

// File: rtl/payload_endian_conv.sv
module payload_endian_conv #(
  parameter int DW        = 64,
  parameter int BCW       = 7,
  parameter int PTW       = 3,
  parameter int MAX_MAINT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              little_endian,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [PTW-1:0]    in_ptype,
  input  logic [BCW-1:0]    in_bytes,
  input  logic              in_target,
  input  logic              in_cfg,
  input  logic [DW-1:0]     in_data,
  input  logic [DW/8-1:0]   in_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DW-1:0]     out_data,
  output logic [DW/8-1:0]   out_be,
  output logic              size_err
);
  localparam int            WORDS    = DW / 32;
  localparam logic [PTW-1:0] PT_MAINT = PTW'(5);
  localparam logic [BCW-1:0] B4       = BCW'(4);

  logic           le_q, tgt_q, cfg_q, drop_q;
  logic [PTW-1:0] pt_q;
  logic [BCW-1:0] by_q;

  wire            in_fire = in_valid && in_ready;
  wire            c_le    = in_sop ? little_endian : le_q;
  wire            c_tgt   = in_sop ? in_target     : tgt_q;
  wire            c_cfg   = in_sop ? in_cfg        : cfg_q;
  wire [PTW-1:0]  c_pt    = in_sop ? in_ptype      : pt_q;
  wire [BCW-1:0]  c_by    = in_sop ? in_bytes      : by_q;

  wire init_ok  = (c_by == B4) ||
                  (c_by[2:0] == 3'd0 && c_by != '0 && int'(c_by) <= MAX_MAINT);
  wire size_bad = !c_cfg && c_pt == PT_MAINT && (c_tgt ? c_by != B4 : !init_ok);
  wire drop_now = in_sop ? size_bad : drop_q;
  wire swap_en  = c_le && !c_cfg && c_pt <= PT_MAINT;

  logic [DW-1:0] conv;
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    wire sel = swap_en && (c_by != B4 || |in_be[4*w +: 4]);
    wire [31:0] wd = in_data[32*w +: 32];
    assign conv[32*w +: 32] = sel ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} : wd;
  end

  assign in_ready = !out_valid || out_ready;
  assign size_err = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_q <= 1'b0; tgt_q <= 1'b0; cfg_q <= 1'b0; drop_q <= 1'b0;
      pt_q <= '0;   by_q  <= '0;
    end else if (in_fire && in_sop) begin
      le_q <= little_endian; tgt_q <= in_target; cfg_q <= in_cfg;
      pt_q <= in_ptype;      by_q  <= in_bytes;  drop_q <= size_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_fire && !drop_now) begin
        out_valid <= 1'b1;
        out_sop   <= in_sop;
        out_eop   <= in_eop;
        out_data  <= conv;
        out_be    <= in_be;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be)); // R10
  AST_BE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !size_err && !in_sop |=> out_valid && out_be == $past(in_be)); // R10
  AST_TGT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_sop && !in_cfg && in_ptype == PT_MAINT && in_target && in_bytes != B4
    |=> size_err && !out_valid); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    size_err && !(in_fire && in_sop) |=> size_err); // R8
  AST_CFG_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_sop && in_cfg |=> out_valid && out_data == $past(in_data)); // R4
  AST_BE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_sop && !little_endian && !size_bad |=> out_data == $past(in_data)); // R1
endmodule

// File: tb/test_payload_endian_conv.sv
module test_payload_endian_conv;
  logic clk = 1'b0, rst_n = 1'b0;
  logic little_endian = 0, in_valid = 0, in_sop = 0, in_eop = 0, in_target = 0, in_cfg = 0;
  logic [2:0] in_ptype = 0;
  logic [6:0] in_bytes = 0;
  logic [63:0] in_data = 0;
  logic [7:0] in_be = 0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_sop, out_eop, size_err;
  logic [63:0] out_data;
  logic [7:0] out_be;

  always #10 clk = ~clk;

  payload_endian_conv i_payload_endian_conv (
    .clk(clk), .rst_n(rst_n), .little_endian(little_endian),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_ptype(in_ptype), .in_bytes(in_bytes), .in_target(in_target), .in_cfg(in_cfg),
    .in_data(in_data), .in_be(in_be), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data), .out_be(out_be),
    .size_err(size_err));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [63:0] q_data[$];
  logic [7:0]  q_be[$];
  logic        q_sop[$], q_eop[$];
  string       q_tag[$];
  bit exp_err = 0, h_le = 0, h_tgt = 0, h_cfg = 0, fired = 0, stall_mode = 0;
  logic [2:0] h_pt = 0;
  logic [6:0] h_by = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit legal(bit cfg, bit tgt, logic [2:0] pt, logic [6:0] by);
    if (cfg || pt != 3'd5) return 1;
    if (tgt) return by == 7'd4;
    return by == 7'd4 || (by % 8 == 0 && by >= 8 && by <= 64);
  endfunction

  function automatic logic [31:0] rev(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // reference model: samples accepted beats and completed outputs at each edge
  always @(posedge clk) begin
    fired = 0;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        n_cmp++;
        if (q_data.size() == 0) begin
          n_bad++; $display("FAIL R10 unexpected beat: actual %h expected none", out_data);
        end else begin
          if (out_data !== q_data[0] || out_be !== q_be[0] ||
              out_sop !== q_sop[0] || out_eop !== q_eop[0]) begin
            n_bad++;
            $display("FAIL %s data/be/sop/eop: actual %h/%h/%b/%b expected %h/%h/%b/%b",
                     q_tag[0], out_data, out_be, out_sop, out_eop,
                     q_data[0], q_be[0], q_sop[0], q_eop[0]);
          end
          void'(q_data.pop_front()); void'(q_be.pop_front());
          void'(q_sop.pop_front());  void'(q_eop.pop_front()); void'(q_tag.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        fired = 1;
        if (in_sop) begin // R9: header only from first beat
          h_le = little_endian; h_tgt = in_target; h_cfg = in_cfg;
          h_pt = in_ptype; h_by = in_bytes;
          exp_err = !legal(h_cfg, h_tgt, h_pt, h_by);
        end
        if (!exp_err) begin
          logic [63:0] d;
          string t;
          d = in_data;
          for (int w = 0; w < 2; w++) begin
            bit conv;
            conv = h_le && !h_cfg && h_pt <= 3'd5 && (h_by != 7'd4 || in_be[4*w +: 4] != 0);
            if (conv) d[32*w +: 32] = rev(in_data[32*w +: 32]);
          end
          if (h_cfg) t = "R4";
          else if (h_by == 7'd4) t = "R5";
          else if (!h_le) t = "R1";
          else if (h_pt <= 3'd5) t = "R2";
          else t = "R3";
          if (!in_sop) t = {t, "/R9"};
          if (stall_mode) t = {t, "/R10"};
          q_data.push_back(d); q_be.push_back(in_be);
          q_sop.push_back(in_sop); q_eop.push_back(in_eop); q_tag.push_back(t);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (size_err !== exp_err) begin
        n_bad++; $display("FAIL R6/R7/R8 size_err: actual %b expected %b", size_err, exp_err);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_mode ? (lfsr[1:0] != 2'b00 && lfsr[3:2] != 2'b00) : 1'b1;
    end
  end

  task automatic send(bit le, logic [2:0] pt, logic [6:0] by, bit tgt, bit cfg,
                      int nbeats, bit upper);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (b == 0); in_eop = (b == nbeats - 1);
      in_data = {$urandom, $urandom};
      in_be = (by == 7'd4) ? (upper ? 8'hF0 : 8'h0F) : 8'hFF;
      if (b == 0) begin
        little_endian = le; in_ptype = pt; in_bytes = by; in_target = tgt; in_cfg = cfg;
      end else begin // R9: junk header on later beats
        little_endian = $urandom; in_ptype = $urandom; in_bytes = $urandom;
        in_target = $urandom; in_cfg = $urandom;
      end
      forever begin
        @(posedge clk); #1;
        if (fired) break;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q_data.size() != 0; i++) @(negedge clk);
  endtask

  task automatic pkt(bit le, logic [2:0] pt, logic [6:0] by, bit tgt, bit cfg, bit upper);
    send(le, pt, by, tgt, cfg, (by <= 8) ? 1 : (int'(by) + 7) / 8, upper);
  endtask

  task automatic suite();
    pkt(0, 3'd0, 7'd32, 0, 0, 0);   // R1
    pkt(0, 3'd4, 7'd16, 0, 0, 0);   // R1
    pkt(1, 3'd0, 7'd24, 0, 0, 0);   // R2
    pkt(1, 3'd1, 7'd8,  0, 0, 0);   // R2
    pkt(1, 3'd2, 7'd16, 0, 0, 0);   // R2
    pkt(1, 3'd3, 7'd40, 0, 0, 0);   // R2
    pkt(1, 3'd4, 7'd16, 0, 0, 0);   // R2
    pkt(1, 3'd5, 7'd16, 0, 0, 0);   // R2 R6 legal
    pkt(1, 3'd6, 7'd16, 0, 0, 0);   // R3
    pkt(1, 3'd7, 7'd8,  0, 0, 0);   // R3
    pkt(1, 3'd5, 7'd16, 1, 1, 0);   // R4 cfg exempt
    pkt(1, 3'd0, 7'd16, 0, 1, 0);   // R4
    pkt(1, 3'd3, 7'd4,  0, 0, 1);   // R5 upper
    pkt(1, 3'd3, 7'd4,  0, 0, 0);   // R5 lower
    pkt(1, 3'd5, 7'd4,  1, 0, 1);   // R5 R7 legal target
    pkt(1, 3'd5, 7'd12, 0, 0, 0);   // R6 illegal
    pkt(1, 3'd5, 7'd72, 0, 0, 0);   // R6 illegal, R8 still set
    pkt(1, 3'd5, 7'd64, 0, 0, 0);   // R6 legal max, R8 clears
    pkt(1, 3'd5, 7'd0,  0, 0, 0);   // R6 zero
    send(1, 3'd5, 7'd0, 0, 0, 2, 0);// R8 dropped beats
    pkt(0, 3'd5, 7'd8,  0, 0, 0);   // R6 legal, R8 clears
    pkt(1, 3'd5, 7'd8,  1, 0, 0);   // R7 illegal
    pkt(1, 3'd2, 7'd16, 0, 0, 0);   // R8 clear after error
    pkt(1, 3'd5, 7'd16, 1, 0, 0);   // R7 illegal
    pkt(1, 3'd5, 7'd4,  0, 0, 0);   // R6 legal 4
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 0 || size_err !== 0 || in_ready !== 1) begin // R11
      n_bad++;
      $display("FAIL R11 reset: actual v=%b e=%b r=%b expected 0/0/1", out_valid, size_err, in_ready);
    end
    rst_n = 1;
    suite();
    drain();
    stall_mode = 1; // R10 backpressure
    suite();
    suite();
    stall_mode = 0;
    drain();
    n_cmp++;
    if (q_data.size() != 0) begin
      n_bad++; $display("FAIL R10 beats lost: actual %0d pending expected 0", q_data.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++; n_cmp++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule